// File: doc/BRIEF.md
# Decoded Micro-Op Cache

This block keeps micro-operations that the decoders have already produced, so that code which runs again can be issued without being decoded a second time. Micro-ops leaving the decode stage are gathered into lines of up to six entries. Each line is stored in a 64-set, 6-way array and is tagged with the fetch address of its first micro-op. A fetch address presented on the lookup port is compared against the tags of the set it indexes. On a hit, the stored line is read out with a mask that marks which of its slots hold real micro-ops.

The lookup result is not handed on at once. It is carried through a fixed four-stage delay line, so a cached line reaches the issue stage in the same cycle the decoders would have delivered the same micro-ops. As a result, the front end can move from the decode path to the cache and back again without a gap or a doubled slot.

Two control inputs act on the cache. A flush drops every stored line and any line that is only partly built. A redirect discards everything in flight in the delay line.

Top module: `uop_cache`

## Requirements
- R1: After reset, out_valid_o is 0 and every lookup misses.
- R2: A lookup that matches a stored line reports a hit. The line's micro-ops come out in the order they were filled: slot 0 is bits [UOP_W-1:0], slot i is bits [i*UOP_W +: UOP_W].
- R3: A lookup presented before clock edge k appears on the outputs after edge k+3, with out_valid_o high for exactly one cycle. Lookups presented on consecutive cycles come out on consecutive cycles, in the same order and with no gap.
- R4: A miss gives out_valid_o=1, out_hit_o=0, out_mask_o=0 and out_uops_o=0. out_addr_o carries the looked-up address on every result.
- R5: A line closed by fill_last_i after n micro-ops reads back with out_mask_o bits [n-1:0] set and the other bits clear. Unused slots read as zero.
- R6: When a trace reaches 6 micro-ops, the line is closed with mask 6'h3F. The next micro-op opens a new line tagged with that micro-op's own fill address.
- R7: Set index is address bits [5:0] and tag is the remaining upper bits. A lookup whose index matches a line but whose tag differs misses.
- R8: A fill into a set goes to the lowest-numbered invalid way. If every way is valid, it goes to the lowest-numbered way whose recently-used mark is clear. A hit or a fill sets the way's mark; if that would set all marks in the set, only the way just used stays marked.
- R9: Filling a line whose address is already stored overwrites that line in place. A later lookup returns the new contents, and at most one way ever matches.
- R10: flush_i invalidates every line at the next edge and discards a partially built line. A fill write due in the same cycle is dropped.
- R11: redirect_i clears every result still in the delay line, and a lookup presented in the same cycle is dropped. Lookups presented later are handled normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Invalidate all lines and abandon the line being built |
| redirect_i | input | 1 | Drop all in-flight results and this cycle's lookup |
| lk_valid_i | input | 1 | Lookup request |
| lk_addr_i | input | ADDR_W | Fetch address to look up |
| fill_valid_i | input | 1 | Decoded micro-op present on the fill port |
| fill_addr_i | input | ADDR_W | Fetch address of the instruction that produced the micro-op |
| fill_uop_i | input | UOP_W | Decoded micro-op |
| fill_last_i | input | 1 | Last micro-op of the current trace |
| out_valid_o | output | 1 | Delayed lookup result present |
| out_hit_o | output | 1 | Result is a hit |
| out_addr_o | output | ADDR_W | Address of the lookup this result belongs to |
| out_mask_o | output | SLOTS | Valid micro-op slots |
| out_uops_o | output | SLOTS*UOP_W | Micro-op slots, slot 0 in the low bits |

## Verification
Back-to-back lookups are checked on every cycle. A delay line that skips or doubles a stage would show up as a gap, a shifted result or results in the wrong order. The replacement test fills seven lines into one set with a hit between fills. A policy that ignores hits, or fails to clear the other marks once all are set, evicts the wrong line, and that shows as a miss on a line that should have stayed.

Traces of exactly six, of seven and of fewer micro-ops test line closing. An off-by-one there gives a wrong mask or a wrong tag on the spill line. A refill of a stored address and a redirect that arrives while results are in flight are also covered. Refill catches a design that writes a duplicate way. The redirect case catches one that still delivers stale or same-cycle lookups. Flush is tested while a line is half built, so a partial line that survives the flush shows up as extra slots.

// File: rtl/uopc_pkg.sv
package uopc_pkg;
  localparam int unsigned DEF_SETS   = 64;
  localparam int unsigned DEF_WAYS   = 6;
  localparam int unsigned DEF_SLOTS  = 6;
  localparam int unsigned DEF_DELAY  = 4;
  localparam int unsigned DEF_UOP_W  = 32;
  localparam int unsigned DEF_ADDR_W = 16;
endpackage

// File: rtl/uopc_fill_builder.sv
module uopc_fill_builder #(
  parameter int unsigned SLOTS  = 6,
  parameter int unsigned UOP_W  = 32,
  parameter int unsigned ADDR_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     flush_i,
  input  logic                     in_valid_i,
  input  logic [ADDR_W-1:0]        in_addr_i,
  input  logic [UOP_W-1:0]         in_uop_i,
  input  logic                     in_last_i,
  output logic                     wr_valid_o,
  output logic [ADDR_W-1:0]        wr_addr_o,
  output logic [SLOTS-1:0]         wr_mask_o,
  output logic [SLOTS*UOP_W-1:0]   wr_data_o
);
  localparam int unsigned SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int unsigned CNT_W  = $clog2(SLOTS + 1);

  logic                          active_q;
  logic [CNT_W-1:0]              cnt_q;
  logic [ADDR_W-1:0]             start_q;
  logic [SLOTS-1:0][UOP_W-1:0]   buf_q;

  logic [SLOTS-1:0][UOP_W-1:0]   buf_n;
  logic [SLOT_W-1:0]             slot;
  logic [CNT_W-1:0]              cnt_n;
  logic [ADDR_W-1:0]             base;
  logic                          close;
  logic [SLOTS-1:0]              mask_n;

  always_comb begin
    buf_n        = active_q ? buf_q : '0;   // new line starts with empty slots
    slot         = active_q ? cnt_q[SLOT_W-1:0] : '0;
    buf_n[slot]  = in_uop_i;
    cnt_n        = CNT_W'(slot) + CNT_W'(1);
    base         = active_q ? start_q : in_addr_i;
    close        = in_last_i || (cnt_n == CNT_W'(SLOTS));
    for (int i = 0; i < SLOTS; i++) mask_n[i] = (CNT_W'(i) < cnt_n);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= 1'b0;
      cnt_q      <= '0;
      start_q    <= '0;
      buf_q      <= '0;
      wr_valid_o <= 1'b0;
      wr_addr_o  <= '0;
      wr_mask_o  <= '0;
      wr_data_o  <= '0;
    end else if (flush_i) begin
      active_q   <= 1'b0;
      wr_valid_o <= 1'b0;
    end else begin
      wr_valid_o <= in_valid_i && close;
      if (in_valid_i) begin
        active_q  <= !close;
        cnt_q     <= cnt_n;
        start_q   <= base;
        buf_q     <= buf_n;
        wr_addr_o <= base;
        wr_mask_o <= mask_n;
        wr_data_o <= buf_n;
      end
    end
  end
endmodule

// File: rtl/uopc_plru.sv
module uopc_plru #(
  parameter int unsigned SETS = 64,
  parameter int unsigned WAYS = 6,
  localparam int unsigned IDX_W = $clog2(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             hit_en_i,
  input  logic [IDX_W-1:0] hit_set_i,
  input  logic [WAYS-1:0]  hit_way_i,
  input  logic             fill_en_i,
  input  logic [IDX_W-1:0] fill_set_i,
  input  logic [WAYS-1:0]  fill_way_i,
  input  logic [IDX_W-1:0] vic_set_i,
  input  logic [WAYS-1:0]  vic_valid_i,
  output logic [WAYS-1:0]  vic_way_o
);
  logic [WAYS-1:0] mru_q [SETS];

  function automatic logic [WAYS-1:0] touch(logic [WAYS-1:0] m, logic [WAYS-1:0] w);
    logic [WAYS-1:0] r;
    r = m | w;
    if (&r) r = w;
    return r;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) mru_q[s] <= '0;
    end else if (flush_i) begin
      for (int s = 0; s < SETS; s++) mru_q[s] <= '0;
    end else begin
      if (hit_en_i) mru_q[hit_set_i] <= touch(mru_q[hit_set_i], hit_way_i);
      if (fill_en_i) begin
        if (hit_en_i && (hit_set_i == fill_set_i))
          mru_q[fill_set_i] <= touch(touch(mru_q[hit_set_i], hit_way_i), fill_way_i);
        else
          mru_q[fill_set_i] <= touch(mru_q[fill_set_i], fill_way_i);
      end
    end
  end

  always_comb begin
    logic found;
    found     = 1'b0;
    vic_way_o = '0;
    for (int w = 0; w < WAYS; w++)
      if (!found && !vic_valid_i[w]) begin
        vic_way_o[w] = 1'b1;
        found        = 1'b1;
      end
    for (int w = 0; w < WAYS; w++)
      if (!found && !mru_q[vic_set_i][w]) begin
        vic_way_o[w] = 1'b1;
        found        = 1'b1;
      end
    if (!found) vic_way_o[0] = 1'b1;
  end
endmodule

// File: rtl/uopc_delay.sv
module uopc_delay #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         in_valid_i,
  input  logic [W-1:0] in_data_i,
  output logic         out_valid_o,
  output logic [W-1:0] out_data_o
);
  logic         vld_q [DEPTH];
  logic [W-1:0] dat_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    logic         v_in;
    logic [W-1:0] d_in;
    if (g == 0) begin : g_head
      assign v_in = in_valid_i;
      assign d_in = in_data_i;
    end else begin : g_body
      assign v_in = vld_q[g-1];
      assign d_in = dat_q[g-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g] <= 1'b0;
        dat_q[g] <= '0;
      end else begin
        vld_q[g] <= clear_i ? 1'b0 : v_in;
        dat_q[g] <= d_in;
      end
    end
  end

  assign out_valid_o = vld_q[DEPTH-1];
  assign out_data_o  = dat_q[DEPTH-1];
endmodule

// File: rtl/uop_cache.sv
module uop_cache
  import uopc_pkg::*;
#(
  parameter int unsigned SETS   = DEF_SETS,
  parameter int unsigned WAYS   = DEF_WAYS,
  parameter int unsigned SLOTS  = DEF_SLOTS,
  parameter int unsigned UOP_W  = DEF_UOP_W,
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned DELAY  = DEF_DELAY
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   flush_i,
  input  logic                   redirect_i,
  input  logic                   lk_valid_i,
  input  logic [ADDR_W-1:0]      lk_addr_i,
  input  logic                   fill_valid_i,
  input  logic [ADDR_W-1:0]      fill_addr_i,
  input  logic [UOP_W-1:0]       fill_uop_i,
  input  logic                   fill_last_i,
  output logic                   out_valid_o,
  output logic                   out_hit_o,
  output logic [ADDR_W-1:0]      out_addr_o,
  output logic [SLOTS-1:0]       out_mask_o,
  output logic [SLOTS*UOP_W-1:0] out_uops_o
);
  localparam int unsigned IDX_W  = $clog2(SETS);
  localparam int unsigned TAG_W  = ADDR_W - IDX_W;
  localparam int unsigned LINE_W = SLOTS * UOP_W;
  localparam int unsigned PAY_W  = 1 + ADDR_W + SLOTS + LINE_W;

  logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
  logic [LINE_W-1:0] data_q [SETS][WAYS];
  logic [SLOTS-1:0]  mask_q [SETS][WAYS];
  logic [WAYS-1:0]   vld_q  [SETS];
  logic              any_vld;

  // fill line builder
  logic              fw_valid;
  logic [ADDR_W-1:0] fw_addr;
  logic [SLOTS-1:0]  fw_mask;
  logic [LINE_W-1:0] fw_data;

  uopc_fill_builder #(.SLOTS(SLOTS), .UOP_W(UOP_W), .ADDR_W(ADDR_W)) u_build (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush_i),
    .in_valid_i (fill_valid_i),
    .in_addr_i  (fill_addr_i),
    .in_uop_i   (fill_uop_i),
    .in_last_i  (fill_last_i),
    .wr_valid_o (fw_valid),
    .wr_addr_o  (fw_addr),
    .wr_mask_o  (fw_mask),
    .wr_data_o  (fw_data)
  );

  // lookup
  logic [IDX_W-1:0]  lk_set;
  logic [TAG_W-1:0]  lk_tag;
  logic [WAYS-1:0]   hit_vec;
  logic              lk_hit;
  logic              lk_go;
  logic [LINE_W-1:0] lk_data;
  logic [SLOTS-1:0]  lk_mask;

  assign lk_set = lk_addr_i[IDX_W-1:0];
  assign lk_tag = lk_addr_i[ADDR_W-1:IDX_W];
  assign lk_go  = lk_valid_i && !redirect_i;
  assign lk_hit = |hit_vec;

  always_comb begin
    hit_vec = '0;
    lk_data = '0;
    lk_mask = '0;
    for (int w = 0; w < WAYS; w++)
      if (vld_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag)) begin
        hit_vec[w] = 1'b1;
        lk_data    = lk_data | data_q[lk_set][w];
        lk_mask    = lk_mask | mask_q[lk_set][w];
      end
  end

  // fill way selection: reuse a matching way, else victim
  logic [IDX_W-1:0] fw_set;
  logic [TAG_W-1:0] fw_tag;
  logic [WAYS-1:0]  match_vec;
  logic [WAYS-1:0]  vic_way;
  logic [WAYS-1:0]  wr_way;
  logic             wr_en;

  assign fw_set = fw_addr[IDX_W-1:0];
  assign fw_tag = fw_addr[ADDR_W-1:IDX_W];
  assign wr_en  = fw_valid && !flush_i;

  always_comb begin
    for (int w = 0; w < WAYS; w++)
      match_vec[w] = vld_q[fw_set][w] && (tag_q[fw_set][w] == fw_tag);
    wr_way = (|match_vec) ? match_vec : vic_way;
  end

  uopc_plru #(.SETS(SETS), .WAYS(WAYS)) u_plru (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush_i),
    .hit_en_i    (lk_go && lk_hit),
    .hit_set_i   (lk_set),
    .hit_way_i   (hit_vec),
    .fill_en_i   (wr_en),
    .fill_set_i  (fw_set),
    .fill_way_i  (wr_way),
    .vic_set_i   (fw_set),
    .vic_valid_i (vld_q[fw_set]),
    .vic_way_o   (vic_way)
  );

  always_ff @(posedge clk_i) begin
    if (wr_en)
      for (int w = 0; w < WAYS; w++)
        if (wr_way[w]) begin
          tag_q[fw_set][w]  <= fw_tag;
          data_q[fw_set][w] <= fw_data;
          mask_q[fw_set][w] <= fw_mask;
        end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (flush_i) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (fw_valid) begin
      vld_q[fw_set] <= vld_q[fw_set] | wr_way;
    end
  end

  always_comb begin
    any_vld = 1'b0;
    for (int s = 0; s < SETS; s++) any_vld = any_vld | (|vld_q[s]);
  end

  // latency-matching delay line
  logic [PAY_W-1:0] pay_in;
  logic [PAY_W-1:0] pay_out;
  logic             pay_hit;
  logic [SLOTS-1:0] pay_mask;

  assign pay_in = {lk_hit, lk_addr_i, lk_mask, lk_data};

  uopc_delay #(.DEPTH(DELAY), .W(PAY_W)) u_delay (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (redirect_i),
    .in_valid_i  (lk_go),
    .in_data_i   (pay_in),
    .out_valid_o (out_valid_o),
    .out_data_o  (pay_out)
  );

  assign {pay_hit, out_addr_o, pay_mask, out_uops_o} = pay_out;
  assign out_hit_o  = out_valid_o && pay_hit;
  assign out_mask_o = out_valid_o ? pay_mask : '0;
endmodule

// File: rtl/uop_cache_chk.sv
module uop_cache_chk #(
  parameter int unsigned WAYS  = 6,
  parameter int unsigned SLOTS = 6,
  parameter int unsigned DELAY = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             flush_i,
  input logic             redirect_i,
  input logic             lk_valid_i,
  input logic             out_valid_o,
  input logic             out_hit_o,
  input logic [SLOTS-1:0] out_mask_o,
  input logic [WAYS-1:0]  hit_vec,
  input logic             fw_valid,
  input logic [SLOTS-1:0] fw_mask,
  input logic             any_vld
);
  logic [DELAY-1:0] shadow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         shadow_q <= '0;
    else if (redirect_i) shadow_q <= '0;
    else                 shadow_q <= (shadow_q << 1) | DELAY'(lk_valid_i);
  end

  assert_latency_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o == shadow_q[DELAY-1]);

  assert_miss_empty_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_hit_o) |-> (out_mask_o == '0));

  assert_mask_prefix_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_hit_o |-> (out_mask_o[0] && ((out_mask_o & (out_mask_o + 1'b1)) == '0)));

  assert_line_nonempty_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fw_valid |-> fw_mask[0]);

  assert_single_way_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));

  assert_flush_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !any_vld);

  assert_redirect_drain_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_i |=> !out_valid_o);
endmodule

bind uop_cache uop_cache_chk #(.WAYS(WAYS), .SLOTS(SLOTS), .DELAY(DELAY)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .flush_i     (flush_i),
  .redirect_i  (redirect_i),
  .lk_valid_i  (lk_valid_i),
  .out_valid_o (out_valid_o),
  .out_hit_o   (out_hit_o),
  .out_mask_o  (out_mask_o),
  .hit_vec     (hit_vec),
  .fw_valid    (fw_valid),
  .fw_mask     (fw_mask),
  .any_vld     (any_vld)
);

// File: tb/uop_cache_bench.sv
module uop_cache_bench;
  localparam int CLK_P  = 10;
  localparam int SLOTS  = 6;
  localparam int UOP_W  = 32;
  localparam int ADDR_W = 16;
  localparam int LINE_W = SLOTS * UOP_W;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              flush_i = 1'b0;
  logic              redirect_i = 1'b0;
  logic              lk_valid_i = 1'b0;
  logic [ADDR_W-1:0] lk_addr_i = '0;
  logic              fill_valid_i = 1'b0;
  logic [ADDR_W-1:0] fill_addr_i = '0;
  logic [UOP_W-1:0]  fill_uop_i = '0;
  logic              fill_last_i = 1'b0;
  logic              out_valid_o;
  logic              out_hit_o;
  logic [ADDR_W-1:0] out_addr_o;
  logic [SLOTS-1:0]  out_mask_o;
  logic [LINE_W-1:0] out_uops_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  uop_cache u_uop_cache (.*);

  task automatic chk(string req, string what, logic [LINE_W-1:0] act, logic [LINE_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [LINE_W-1:0] mk_line(logic [UOP_W-1:0] base, int n);
    logic [LINE_W-1:0] r = '0;
    for (int i = 0; i < SLOTS; i++)
      if (i < n) r[i*UOP_W +: UOP_W] = base + UOP_W'(i);
    return r;
  endfunction

  function automatic logic [SLOTS-1:0] mk_mask(int n);
    return SLOTS'((1 << n) - 1);
  endfunction

  task automatic drive_fill(logic [ADDR_W-1:0] a, logic [UOP_W-1:0] u, logic last);
    @(negedge clk_i);
    fill_valid_i = 1'b1; fill_addr_i = a; fill_uop_i = u; fill_last_i = last;
  endtask

  task automatic fill_stop();
    @(negedge clk_i);
    fill_valid_i = 1'b0; fill_last_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic fill_line(logic [ADDR_W-1:0] a, int n, logic [UOP_W-1:0] base);
    for (int i = 0; i < n; i++) drive_fill(a, base + UOP_W'(i), i == n - 1);
    fill_stop();
  endtask

  // presented before edge e0, result visible after edge e0+3
  task automatic lookup(string req, logic [ADDR_W-1:0] a, logic hit, int n, logic [UOP_W-1:0] base);
    @(negedge clk_i);
    lk_valid_i = 1'b1; lk_addr_i = a;
    @(negedge clk_i);
    lk_valid_i = 1'b0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk(req, "valid", LINE_W'(out_valid_o), LINE_W'(1));
    chk(req, "hit", LINE_W'(out_hit_o), LINE_W'(hit));
    chk(req, "addr", LINE_W'(out_addr_o), LINE_W'(a));
    chk(req, "mask", LINE_W'(out_mask_o), hit ? LINE_W'(mk_mask(n)) : '0);
    chk(req, "uops", out_uops_o, hit ? mk_line(base, n) : '0);
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    chk("R1", "valid after reset", LINE_W'(out_valid_o), '0);
    lookup("R1", 16'h0040, 1'b0, 0, 0);
    lookup("R4", 16'h1003, 1'b0, 0, 0);
  endtask

  task automatic t_basic();
    fill_line(16'h1003, 6, 32'h100);
    lookup("R2", 16'h1003, 1'b1, 6, 32'h100);
  endtask

  task automatic t_partial();
    fill_line(16'h2007, 3, 32'h200);
    lookup("R5", 16'h2007, 1'b1, 3, 32'h200);
  endtask

  task automatic t_tag();
    lookup("R7", 16'h3003, 1'b0, 0, 0);
  endtask

  task automatic t_stream();
    logic [ADDR_W-1:0] a [3] = '{16'h1003, 16'h3003, 16'h2007};
    logic              h [3] = '{1'b1, 1'b0, 1'b1};
    int                n [3] = '{6, 0, 3};
    logic [UOP_W-1:0]  b [3] = '{32'h100, 32'h0, 32'h200};
    for (int c = 0; c < 9; c++) begin
      @(negedge clk_i);
      if (c >= 4 && c < 7) begin
        chk("R3", "stream valid", LINE_W'(out_valid_o), LINE_W'(1));
        chk("R3", "stream addr", LINE_W'(out_addr_o), LINE_W'(a[c-4]));
        chk("R3", "stream hit", LINE_W'(out_hit_o), LINE_W'(h[c-4]));
        chk("R3", "stream uops", out_uops_o, h[c-4] ? mk_line(b[c-4], n[c-4]) : '0);
      end else begin
        chk("R3", "stream idle", LINE_W'(out_valid_o), '0);
      end
      lk_valid_i = (c < 3);
      if (c < 3) lk_addr_i = a[c];
    end
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 6; i++) drive_fill(16'h4010, 32'h700 + UOP_W'(i), 1'b0);
    drive_fill(16'h4011, 32'h706, 1'b1);
    fill_stop();
    lookup("R6", 16'h4010, 1'b1, 6, 32'h700);
    lookup("R6", 16'h4011, 1'b1, 1, 32'h706);
  endtask

  task automatic t_replace();
    for (int k = 0; k < 6; k++) fill_line(ADDR_W'((k + 1) * 64 + 37), 1, 32'h500 + UOP_W'(k));
    lookup("R8", ADDR_W'(64 + 37), 1'b1, 1, 32'h500);
    fill_line(ADDR_W'(7 * 64 + 37), 1, 32'h506);
    lookup("R8", ADDR_W'(2 * 64 + 37), 1'b0, 0, 0);   // way 1 evicted
    lookup("R8", ADDR_W'(64 + 37), 1'b1, 1, 32'h500);
    lookup("R8", ADDR_W'(7 * 64 + 37), 1'b1, 1, 32'h506);
    lookup("R8", ADDR_W'(3 * 64 + 37), 1'b1, 1, 32'h502);
  endtask

  task automatic t_refill();
    fill_line(16'h1003, 2, 32'h900);
    lookup("R9", 16'h1003, 1'b1, 2, 32'h900);
  endtask

  task automatic t_redirect();
    for (int c = 0; c < 9; c++) begin
      @(negedge clk_i);
      if (c >= 3) chk("R11", "drained", LINE_W'(out_valid_o), '0);
      lk_valid_i = (c == 0) || (c == 2);
      lk_addr_i  = (c == 0) ? 16'h1003 : 16'h2007;
      redirect_i = (c == 2);
    end
    lk_valid_i = 1'b0;
    lookup("R11", 16'h2007, 1'b1, 3, 32'h200);
  endtask

  task automatic t_flush();
    drive_fill(16'h6001, 32'hB00, 1'b0);
    drive_fill(16'h6001, 32'hB01, 1'b0);
    @(negedge clk_i);
    fill_valid_i = 1'b0; flush_i = 1'b1;
    @(negedge clk_i);
    flush_i = 1'b0;
    lookup("R10", 16'h1003, 1'b0, 0, 0);
    lookup("R10", 16'h2007, 1'b0, 0, 0);
    fill_line(16'h6001, 1, 32'hA00);
    lookup("R10", 16'h6001, 1'b1, 1, 32'hA00);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk_i);
    n_fail++;
    $display("FAIL R3 watchdog: actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_basic();
    t_partial();
    t_tag();
    t_stream();
    t_overflow();
    t_replace();
    t_refill();
    t_redirect();
    t_flush();
    repeat (4) @(posedge clk_i);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule